// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two external-bus strobes of an 8-bit controller core that runs from an oscillator-rate clock. The strobes are the address-latch pulse (`ale`, active high) and the active-low program-fetch read strobe (`psen_n`). A machine cycle lasts twelve oscillator periods. The block counts these periods with a phase counter that it also drives out to the rest of the core. The address-latch pulse normally fires twice per machine cycle, six oscillator periods apart. The fetch strobe fires twice per cycle, but only while the core executes from external program memory.

Two kinds of suppression shape the strobes:

- **External data access.** When the core flags the current machine cycle as one, the second address-latch pulse is dropped. Both fetch strobes of that cycle are also dropped.
- **Software latch-off.** A single software-written control bit switches the address-latch pulse off. While the bit is set, the pulse still appears during data-move or code-table-read instructions. The bit has no effect while the core runs from external program memory.

The reset pin is filtered. It must be held low for two full machine cycles of running oscillator before the phase counter and the control bit are cleared. The strobes go inactive as soon as the pin is low.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase` advances by one on each clock with `osc_en` high and wraps from 11 to 0. It holds its value on clocks with `osc_en` low.
- R2: In a cycle with no external data access and the latch-off bit clear, `ale` is high exactly at phases 0, 1, 6 and 7.
- R3: When `xdata_cycle` is high, `ale` stays low at phases 6 and 7, and the pulse at phases 0 and 1 still occurs when otherwise allowed.
- R4: With `ext_exec` high and `xdata_cycle` low, `psen_n` is low exactly at phases 3, 4, 5, 9, 10 and 11.
- R5: With `ext_exec` low, `psen_n` stays high.
- R6: With `ext_exec` and `xdata_cycle` both high, `psen_n` stays high for the whole cycle.
- R7: With the latch-off bit set and both `ext_exec` and `movx_movc` low, `ale` stays low.
- R8: With the latch-off bit set and `movx_movc` high, `ale` pulses as in R2 and R3.
- R9: With `ext_exec` high, the latch-off bit has no effect on `ale`.
- R10: A clock with `aux_wr_en` high loads `aux_wr_data` into the latch-off bit (1 = latch off). After a completed reset the bit is 0.
- R11: Reset completes only after `rst_n` has been low for 24 consecutive `osc_en` clocks. It then holds `phase` at 0 and clears the latch-off bit. A shorter low pulse leaves `phase` counting and the bit unchanged.
- R12: While `rst_n` is low, `ale` is low and `psen_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Raw active-low reset pin, filtered internally |
| osc_en | input | 1 | Oscillator-period enable; one phase step per high clock |
| xdata_cycle | input | 1 | Current machine cycle accesses external data memory |
| movx_movc | input | 1 | A data-move or code-table-read instruction is executing |
| ext_exec | input | 1 | Core is executing from external program memory |
| aux_wr_en | input | 1 | Write strobe for the latch-off control bit |
| aux_wr_data | input | 1 | Value written to the latch-off control bit |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| phase | output | 4 | Oscillator period within the machine cycle, 0 to 11 |

## Verification
The bench sweeps every relevant combination of execution mode, data-access flag, instruction flag and latch-off bit. For each combination it captures a whole machine cycle as a twelve-bit waveform per strobe. A wrong pulse position, a dropped pulse in the wrong slot, or a suppression rule that leaks into another mode each shows up as a different mask. Pairs such as "latch-off set with internal execution" against "latch-off set with external execution" separate the override rule from the basic disable. Directed sequences compare a half-length reset pulse with a full-length one; this tells the reset filter apart from a plain synchronous clear. Further sequences stall the oscillator enable and watch the 11-to-0 wrap.

// File: rtl/strobe_pkg.sv
// Shared timing constants for the external bus strobe generator.
// Assumes a machine cycle split into two equal halves, each carrying
// one address-latch pulse and one program-fetch strobe.
package strobe_pkg;
    localparam int unsigned CYC_LEN_DEF    = 12; // oscillator periods per machine cycle
    localparam int unsigned RST_CYC_DEF    = 2;  // machine cycles of low reset needed
    localparam int unsigned ALE_OFS_DEF    = 0;  // latch pulse start within a half cycle
    localparam int unsigned ALE_LEN_DEF    = 2;  // latch pulse width
    localparam int unsigned PSEN_OFS_DEF   = 3;  // fetch strobe start within a half cycle
    localparam int unsigned PSEN_LEN_DEF   = 3;  // fetch strobe width
    localparam int unsigned PULSES_PER_CYC = 2;  // strobes of each kind per machine cycle
endpackage

// File: rtl/strobe_rst_filter.sv
// Reset qualifier: asserts core_rst once rst_n has been low for HOLD
// consecutive oscillator-enabled clocks. Assumes rst_n is synchronous
// to clk. The counter is itself cleared synchronously by rst_n high.
module strobe_rst_filter #(
    parameter int unsigned HOLD = 24,
    localparam int unsigned CW  = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    output logic core_rst
);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] low_cnt;

    // Count oscillator periods spent with the pin low, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            low_cnt <= '0;
        end else if (osc_en && (low_cnt != HOLD_V)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Reset is effective once the full hold time has elapsed.
    always_comb core_rst = (low_cnt == HOLD_V);
endmodule

// File: rtl/strobe_phase_ctr.sv
// Machine-cycle phase counter: steps once per oscillator enable and
// wraps after CYC_LEN periods. Held at zero by the qualified reset.
module strobe_phase_ctr #(
    parameter int unsigned CYC_LEN = 12,
    localparam int unsigned PW     = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          core_rst,
    input  logic          osc_en,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

    // Advance the phase, wrapping at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (core_rst) begin
            phase <= '0;
        end else if (osc_en) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/strobe_window.sv
// Phase window decoder: hit is high while phase lies in
// [START, START+LEN). Assumes START+LEN does not pass the cycle end and
// that the modular difference of a phase below START exceeds LEN.
module strobe_window #(
    parameter int unsigned PW    = 4,
    parameter int unsigned START = 0,
    parameter int unsigned LEN   = 2
) (
    input  logic [PW-1:0] phase,
    output logic          hit
);
    localparam logic [PW-1:0] S_V = PW'(START);
    localparam logic [PW-1:0] L_V = PW'(LEN);

    logic [PW-1:0] rel;

    // Offset from window start, modulo the counter width.
    always_comb rel = phase - S_V;
    // Inside the window when the offset is below the width.
    always_comb hit = (rel < L_V);
endmodule

// File: rtl/strobe_shaper.sv
// Strobe shaping: decodes the latch and fetch windows from the phase and
// applies the data-access, latch-off and reset suppression rules.
// Assumes the mode inputs are stable across the cycle they qualify.
module strobe_shaper #(
    parameter int unsigned CYC_LEN  = 12,
    parameter int unsigned NPULSE   = 2,
    parameter int unsigned ALE_OFS  = 0,
    parameter int unsigned ALE_LEN  = 2,
    parameter int unsigned PSEN_OFS = 3,
    parameter int unsigned PSEN_LEN = 3,
    localparam int unsigned PW      = $clog2(CYC_LEN),
    localparam int unsigned SLOT    = CYC_LEN / NPULSE
) (
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    input  logic          xdata_cycle,
    input  logic          movx_movc,
    input  logic          ext_exec,
    input  logic          ale_off,
    output logic          ale,
    output logic          psen_n
);
    logic [NPULSE-1:0] ale_hit;
    logic [NPULSE-1:0] ale_keep;
    logic [NPULSE-1:0] psen_hit;

    for (genvar k = 0; k < NPULSE; k++) begin : g_slot
        strobe_window #(
            .PW(PW), .START(k * SLOT + ALE_OFS), .LEN(ALE_LEN)
        ) u_ale_win (
            .phase(phase), .hit(ale_hit[k])
        );
        strobe_window #(
            .PW(PW), .START(k * SLOT + PSEN_OFS), .LEN(PSEN_LEN)
        ) u_psen_win (
            .phase(phase), .hit(psen_hit[k])
        );
        if (k == NPULSE - 1) begin : g_skip
            // The final latch pulse gives way to a data access.
            always_comb ale_keep[k] = ale_hit[k] & ~xdata_cycle;
        end else begin : g_keep
            // Earlier latch pulses always survive a data access.
            always_comb ale_keep[k] = ale_hit[k];
        end
    end

    logic ale_allowed;

    // Latch-off bit is overridden by external execution or a data move.
    always_comb ale_allowed = ~ale_off | ext_exec | movx_movc;

    // Address-latch output, forced low while the reset pin is low.
    always_comb ale = rst_n & ale_allowed & (|ale_keep);

    // Fetch strobe only during external execution outside data cycles.
    always_comb psen_n = ~(rst_n & ext_exec & ~xdata_cycle & (|psen_hit));
endmodule

// File: rtl/bus_strobe_gen.sv
// External bus strobe generator top: reset filter, phase counter,
// latch-off control bit and strobe shaper. Assumes every input is
// synchronous to clk; osc_en marks one oscillator period.
module bus_strobe_gen
    import strobe_pkg::*;
#(
    parameter int unsigned CYC_LEN  = CYC_LEN_DEF,
    parameter int unsigned RST_CYC  = RST_CYC_DEF,
    parameter int unsigned ALE_OFS  = ALE_OFS_DEF,
    parameter int unsigned ALE_LEN  = ALE_LEN_DEF,
    parameter int unsigned PSEN_OFS = PSEN_OFS_DEF,
    parameter int unsigned PSEN_LEN = PSEN_LEN_DEF,
    localparam int unsigned PW      = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_en,
    input  logic          xdata_cycle,
    input  logic          movx_movc,
    input  logic          ext_exec,
    input  logic          aux_wr_en,
    input  logic          aux_wr_data,
    output logic          ale,
    output logic          psen_n,
    output logic [PW-1:0] phase
);
    logic core_rst;
    logic ale_off;

    strobe_rst_filter #(.HOLD(RST_CYC * CYC_LEN)) u_rst (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .core_rst(core_rst)
    );

    strobe_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk(clk), .core_rst(core_rst), .osc_en(osc_en), .phase(phase)
    );

    // Software latch-off control bit, cleared by the qualified reset.
    always_ff @(posedge clk) begin
        if (core_rst) begin
            ale_off <= 1'b0;
        end else if (aux_wr_en) begin
            ale_off <= aux_wr_data;
        end
    end

    strobe_shaper #(
        .CYC_LEN(CYC_LEN), .NPULSE(PULSES_PER_CYC),
        .ALE_OFS(ALE_OFS), .ALE_LEN(ALE_LEN),
        .PSEN_OFS(PSEN_OFS), .PSEN_LEN(PSEN_LEN)
    ) u_shape (
        .rst_n(rst_n), .phase(phase), .xdata_cycle(xdata_cycle),
        .movx_movc(movx_movc), .ext_exec(ext_exec), .ale_off(ale_off),
        .ale(ale), .psen_n(psen_n)
    );
endmodule

// File: rtl/bus_strobe_gen_chk.sv
// Protocol checker for bus_strobe_gen, bound to every instance.
// Observes ports plus the qualified reset and the latch-off bit.
module bus_strobe_gen_chk #(
    parameter int unsigned CYC_LEN = 12,
    localparam int unsigned PW     = $clog2(CYC_LEN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          osc_en,
    input logic          xdata_cycle,
    input logic          movx_movc,
    input logic          ext_exec,
    input logic          ale,
    input logic          psen_n,
    input logic [PW-1:0] phase,
    input logic          core_rst,
    input logic          ale_off
);
    localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);
    localparam logic [PW-1:0] HALF = PW'(CYC_LEN / 2);

    assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !core_rst) |=>
            (phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1)));

    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !core_rst) |=> $stable(phase));

    assert_ale_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xdata_cycle && (phase == HALF || phase == HALF + 1'b1)) |-> !ale);

    assert_psen_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_exec |-> psen_n);

    assert_psen_xdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_exec && xdata_cycle) |-> psen_n);

    assert_ale_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_off && !ext_exec && !movx_movc) |-> !ale);

    assert_reset_clears_R11: assert property (@(posedge clk)
        core_rst |=> (phase == '0 && !ale_off));

    assert_strobe_hold_R12: assert property (@(posedge clk)
        !rst_n |-> (!ale && psen_n));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.CYC_LEN(CYC_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .xdata_cycle(xdata_cycle),
    .movx_movc(movx_movc), .ext_exec(ext_exec), .ale(ale), .psen_n(psen_n),
    .phase(phase), .core_rst(core_rst), .ale_off(ale_off)
);

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/1ps
module bus_strobe_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       osc_en = 1'b1;
    logic       xdata_cycle = 1'b0;
    logic       movx_movc = 1'b0;
    logic       ext_exec = 1'b0;
    logic       aux_wr_en = 1'b0;
    logic       aux_wr_data = 1'b0;
    logic       ale;
    logic       psen_n;
    logic [3:0] phase;

    int n_run  = 0;
    int n_fail = 0;

    bus_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .xdata_cycle(xdata_cycle),
        .movx_movc(movx_movc), .ext_exec(ext_exec), .aux_wr_en(aux_wr_en),
        .aux_wr_data(aux_wr_data), .ale(ale), .psen_n(psen_n), .phase(phase)
    );

    always #2.5 clk = ~clk;

    // Vector: {ext, xdata, movx, latch_off, ale_mask[11:0], psen_low_mask[11:0]}
    // Mask bit i = strobe asserted at phase i.
    localparam int NVEC = 10;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'b0000, 12'h0C3, 12'h000},  // R2 R5 plain internal
        {4'b0100, 12'h003, 12'h000},  // R3 data access drops second latch
        {4'b1000, 12'h0C3, 12'hE38},  // R4 external execution
        {4'b1100, 12'h003, 12'h000},  // R6 data access drops both fetches
        {4'b0001, 12'h000, 12'h000},  // R7 latch off
        {4'b0011, 12'h0C3, 12'h000},  // R8 latch off, data move
        {4'b0111, 12'h003, 12'h000},  // R8 latch off, data move + access
        {4'b1001, 12'h0C3, 12'hE38},  // R9 external execution overrides
        {4'b1101, 12'h003, 12'h000},  // R9 override with data access
        {4'b0101, 12'h000, 12'h000}   // R7 latch off with data access
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_aux(input logic v);
        aux_wr_data = v;
        aux_wr_en = 1'b1;
        @(negedge clk);
        aux_wr_en = 1'b0;
    endtask

    task automatic capture(output logic [11:0] am, output logic [11:0] pm);
        while (phase != 4'd0) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            am[i] = ale;
            pm[i] = ~psen_n;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] am, pm;
        logic [3:0]  p0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (30) @(negedge clk);
        // R12 R11 reset state
        check("R12 reset strobes", {30'd0, ale, psen_n}, 32'h1);
        check("R11 reset phase", 32'(phase), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 latch-off clear after reset", 32'(ale), 32'd1);

        for (int v = 0; v < NVEC; v++) begin
            ext_exec    = VEC[v][27];
            xdata_cycle = VEC[v][26];
            movx_movc   = VEC[v][25];
            write_aux(VEC[v][24]);
            capture(am, pm);
            check($sformatf("R2-vector%0d ale", v), 32'(am), 32'(VEC[v][23:12]));
            check($sformatf("R4-vector%0d psen", v), 32'(pm), 32'(VEC[v][11:0]));
        end

        // R1 stall: phase holds while osc_en low
        ext_exec = 1'b0; xdata_cycle = 1'b0; movx_movc = 1'b0;
        write_aux(1'b0);
        while (phase != 4'd4) @(negedge clk);
        osc_en = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 stall hold", 32'(phase), 32'd4);
        osc_en = 1'b1;
        @(negedge clk);
        check("R1 resume step", 32'(phase), 32'd5);
        while (phase != 4'd11) @(negedge clk);
        @(negedge clk);
        check("R1 wrap", 32'(phase), 32'd0);

        // R11 short reset pulse keeps state; R12 strobes idle meanwhile
        write_aux(1'b1);
        ext_exec = 1'b1;
        p0 = phase;
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R12 strobes idle in short reset", {30'd0, ale, psen_n}, 32'h1);
        repeat (6) @(negedge clk);
        check("R11 phase runs through short reset", 32'(phase), 32'(p0));
        rst_n = 1'b1;
        ext_exec = 1'b0;
        capture(am, pm);
        check("R11 latch-off kept after short reset", 32'(am), 32'h000);

        // R11 full reset clears latch-off bit and restarts phase
        rst_n = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 phase restart", 32'(phase), 32'd0);
        capture(am, pm);
        check("R10 latch-off cleared by full reset", 32'(am), 32'h0C3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule